// File: doc/BRIEF.md
# Complementary PWM Output Guard

This block stands between a six-phase complementary PWM generator and the pins it drives. On the CPU side it filters every register access aimed at the generator. A lock bit blocks the generator's configuration registers (mode, control, compare and counter) so that a runaway program cannot corrupt them. The generator's buffer registers stay open at all times, so duty updates can continue while the configuration is frozen.

On the pin side it removes all six output enables at once. This happens when any enabled one of four active-low fault inputs asserts, or when the main clock stops. A stopped main clock is detected by a small watchdog that runs on a separate slow reference clock. Every trip is sticky: the outputs stay released only after software clears the flag with a write-one-to-clear, and the clear is refused while the cause is still present. The block also turns the generator's first-channel A compare match into a one-cycle start pulse for the A/D converter. That match falls at the carrier centre, and the block issues at most one pulse per carrier period.

Top module: `pwm_guard`

## Requirements
- R1: After reset, CTRL (local index 0) reads 0, the fault mask (index 1) reads 4'hF, the status (index 2) reads 0, and `pwm_oe` equals `gen_oe`.
- R2: While CTRL bit 0 (lock) is 1, an access to the protected window has no effect on the generator. This window is `cpu_addr` 0x00–0x0F. A write there raises no `gen_wr`, and the generator content is unchanged. A read raises no `gen_rd` and returns all ones.
- R3: Buffer addresses 0x10–0x1F pass writes and reads to the generator whatever the lock state.
- R4: With the lock clear, protected addresses pass writes and reads to the generator unchanged.
- R5: A low level on `flt_n[i]` while mask bit i is 1 sets status bit i. It also drives all six `pwm_oe` low by the third rising clock edge after the input falls.
- R6: A low level on a pin whose mask bit is 0 sets no flag and leaves `pwm_oe` equal to `gen_oe`.
- R7: Writing 1 to status bit i clears that flag only if `flt_n[i]` has already returned high and passed the synchroniser. A clear written while the pin is still low is ignored.
- R8: If `clk` stops toggling for `HALT_LIM` reference cycles, a halt flag sets. The halt flag is status bit 4. When it sets, `pwm_oe` goes all low with no `clk` edge needed.
- R9: The halt flag and the released outputs persist after `clk` restarts. They end only when 1 is written to status bit 4.
- R10: When CTRL bit 1 (trigger enable) is 1, a rising edge on `match_a` makes `adc_start` high for exactly the next cycle. Only one pulse is issued between two `carrier_start` pulses. With the bit at 0, no pulse is issued.
- R11: While no flag is set, `pwm_oe` follows `gen_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| ref_clk | input | 1 | Slow independent reference clock for the halt watchdog |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | 6 | Word address; bit 5 selects local registers, bit 4 selects buffer registers |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data (combinational) |
| gen_wr | output | 1 | Write strobe forwarded to the generator |
| gen_rd | output | 1 | Read strobe forwarded to the generator |
| gen_addr | output | 5 | Generator register address |
| gen_wdata | output | 16 | Generator write data |
| gen_rdata | input | 16 | Generator read data |
| flt_n | input | 4 | Active-low external fault inputs |
| gen_oe | input | 6 | Output enables requested by the generator |
| pwm_oe | output | 6 | Output enables to the pin drivers (0 = high impedance) |
| carrier_start | input | 1 | One-cycle pulse at the start of each carrier period |
| match_a | input | 1 | First-channel A-register compare match (carrier centre) |
| adc_start | output | 1 | One-cycle A/D conversion start request |

## Verification
The hardest state to reach is the oscillator-halt trip. In that state the main clock is absent, so nothing in the main domain can react, and the only proof of the trip is the pin enables falling. The bench gates its own main clock generator and leaves the reference clock running. It checks `pwm_oe` after a wait in plain time units rather than in clock edges. It then restarts the clock and shows that the trip survives until the clear reaches the reference domain and comes back.

// File: rtl/pwm_guard_pkg.sv
package pwm_guard_pkg;

  typedef enum logic [1:0] {
    ACC_PROT  = 2'd0,
    ACC_BUF   = 2'd1,
    ACC_LOCAL = 2'd2
  } acc_e;

  localparam int LOC_CTRL = 0;
  localparam int LOC_MASK = 1;
  localparam int LOC_STAT = 2;

  localparam int CTRL_LOCK = 0;
  localparam int CTRL_TRIG = 1;

  function automatic acc_e classify(input logic local_sel, input logic buf_sel);
    if (local_sel)    return ACC_LOCAL;
    else if (buf_sel) return ACC_BUF;
    else              return ACC_PROT;
  endfunction

endpackage

// File: rtl/pwm_guard_gate.sv
module pwm_guard_gate
  import pwm_guard_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LOC_AW = 2
) (
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              lock,
  output logic              gen_wr,
  output logic              gen_rd,
  output logic [ADDR_W-2:0] gen_addr,
  output logic [DATA_W-1:0] gen_wdata,
  input  logic [DATA_W-1:0] gen_rdata,
  output logic              loc_wr,
  output logic [LOC_AW-1:0] loc_idx,
  input  logic [DATA_W-1:0] loc_rdata,
  output logic              denied
);

  acc_e cls;
  logic deny;

  assign cls  = classify(cpu_addr[ADDR_W-1], cpu_addr[ADDR_W-2]);
  assign deny = lock && (cls == ACC_PROT);

  assign gen_addr  = cpu_addr[ADDR_W-2:0];
  assign gen_wdata = cpu_wdata;
  assign gen_wr    = cpu_wr && (cls != ACC_LOCAL) && !deny;
  assign gen_rd    = cpu_rd && (cls != ACC_LOCAL) && !deny;
  assign loc_wr    = cpu_wr && (cls == ACC_LOCAL);
  assign loc_idx   = cpu_addr[LOC_AW-1:0];
  assign denied    = (cpu_wr || cpu_rd) && deny;

  always_comb begin
    if (cls == ACC_LOCAL) cpu_rdata = loc_rdata;
    else if (deny)        cpu_rdata = '1;
    else                  cpu_rdata = gen_rdata;
  end

endmodule

// File: rtl/pwm_guard_fault.sv
module pwm_guard_fault #(
  parameter int N_FLT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_FLT-1:0] flt_n,
  input  logic [N_FLT-1:0] mask,
  input  logic [N_FLT-1:0] clr,
  output logic [N_FLT-1:0] flags,
  output logic [N_FLT-1:0] active
);

  logic [N_FLT-1:0][SYNC_STAGES-1:0] sync_q;

  for (genvar i = 0; i < N_FLT; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[i] <= '1;
      else        sync_q[i] <= {sync_q[i][SYNC_STAGES-2:0], flt_n[i]};
    end

    assign active[i] = ~sync_q[i][SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    flags[i] <= 1'b0;
      else if (active[i] && mask[i]) flags[i] <= 1'b1;
      else if (clr[i] && !active[i]) flags[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_guard_osc.sv
module pwm_guard_osc #(
  parameter int HALT_LIM    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic clr_req,
  output logic halt_ref,
  output logic halt_seen,
  output logic starved
);

  localparam int CNT_W = $clog2(HALT_LIM + 1);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(HALT_LIM);

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic beat);
    if (beat)        return '0;
    else if (c >= LIM_C) return LIM_C;
    else             return c + 1'b1;
  endfunction

  logic                   beat_q, clr_tgl;
  logic [SYNC_STAGES-1:0] beat_s, clr_s, seen_s;
  logic                   beat_prev, clr_prev;
  logic [CNT_W-1:0]       cnt;
  logic                   beat_edge, clr_edge;

  // main-clock side: a divide-by-two beat and a clear toggle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q  <= 1'b0;
      clr_tgl <= 1'b0;
    end else begin
      beat_q  <= ~beat_q;
      clr_tgl <= clr_tgl ^ clr_req;
    end
  end

  // reference side
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_s    <= '0;
      clr_s     <= '0;
      beat_prev <= 1'b0;
      clr_prev  <= 1'b0;
    end else begin
      beat_s    <= {beat_s[SYNC_STAGES-2:0], beat_q};
      clr_s     <= {clr_s[SYNC_STAGES-2:0], clr_tgl};
      beat_prev <= beat_s[SYNC_STAGES-1];
      clr_prev  <= clr_s[SYNC_STAGES-1];
    end
  end

  assign beat_edge = beat_s[SYNC_STAGES-1] ^ beat_prev;
  assign clr_edge  = clr_s[SYNC_STAGES-1] ^ clr_prev;
  assign starved   = (cnt == LIM_C);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      halt_ref <= 1'b0;
    end else begin
      cnt <= next_count(cnt, beat_edge);
      if (starved)       halt_ref <= 1'b1;
      else if (clr_edge) halt_ref <= 1'b0;
    end
  end

  // flag back into the main domain for status reads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_s <= '0;
    else        seen_s <= {seen_s[SYNC_STAGES-2:0], halt_ref};
  end

  assign halt_seen = seen_s[SYNC_STAGES-1];

endmodule

// File: rtl/pwm_guard_adc.sv
module pwm_guard_adc (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic match_a,
  input  logic carrier_start,
  output logic adc_start,
  output logic fire
);

  logic match_d, armed;

  assign fire = en && armed && match_a && !match_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_d   <= 1'b0;
      armed     <= 1'b1;
      adc_start <= 1'b0;
    end else begin
      match_d   <= match_a;
      adc_start <= fire;
      if (carrier_start) armed <= 1'b1;
      else if (fire)     armed <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_guard.sv
module pwm_guard
  import pwm_guard_pkg::*;
#(
  parameter int N_PHASE     = 6,
  parameter int N_FLT       = 4,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int HALT_LIM    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               cpu_wr,
  input  logic               cpu_rd,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               gen_wr,
  output logic               gen_rd,
  output logic [ADDR_W-2:0]  gen_addr,
  output logic [DATA_W-1:0]  gen_wdata,
  input  logic [DATA_W-1:0]  gen_rdata,
  input  logic [N_FLT-1:0]   flt_n,
  input  logic [N_PHASE-1:0] gen_oe,
  output logic [N_PHASE-1:0] pwm_oe,
  input  logic               carrier_start,
  input  logic               match_a,
  output logic               adc_start
);

  localparam int LOC_AW   = 2;
  localparam int HALT_BIT = N_FLT;

  logic              lock_q, trig_en_q;
  logic [N_FLT-1:0]  mask_q;
  logic              loc_wr;
  logic [LOC_AW-1:0] loc_idx;
  logic [DATA_W-1:0] loc_rdata;
  logic              denied;
  logic              stat_wr;
  logic [N_FLT-1:0]  flt_clr, flags, flt_act;
  logic              halt_clr, halt_ref, halt_seen, starved;
  logic              trip, adc_fire;

  pwm_guard_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOC_AW(LOC_AW)) u_gate (
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .lock(lock_q),
    .gen_wr(gen_wr), .gen_rd(gen_rd), .gen_addr(gen_addr), .gen_wdata(gen_wdata),
    .gen_rdata(gen_rdata), .loc_wr(loc_wr), .loc_idx(loc_idx),
    .loc_rdata(loc_rdata), .denied(denied)
  );

  // local registers: control and fault mask
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      trig_en_q <= 1'b0;
      mask_q    <= '1;
    end else if (loc_wr) begin
      if (loc_idx == LOC_AW'(LOC_CTRL)) begin
        lock_q    <= cpu_wdata[CTRL_LOCK];
        trig_en_q <= cpu_wdata[CTRL_TRIG];
      end
      if (loc_idx == LOC_AW'(LOC_MASK)) mask_q <= cpu_wdata[N_FLT-1:0];
    end
  end

  assign stat_wr  = loc_wr && (loc_idx == LOC_AW'(LOC_STAT));
  assign flt_clr  = stat_wr ? cpu_wdata[N_FLT-1:0] : '0;
  assign halt_clr = stat_wr && cpu_wdata[HALT_BIT];

  always_comb begin
    loc_rdata = '0;
    case (loc_idx)
      LOC_AW'(LOC_CTRL): begin
        loc_rdata[CTRL_LOCK] = lock_q;
        loc_rdata[CTRL_TRIG] = trig_en_q;
      end
      LOC_AW'(LOC_MASK): loc_rdata[N_FLT-1:0] = mask_q;
      LOC_AW'(LOC_STAT): loc_rdata[HALT_BIT:0] = {halt_seen, flags};
      default: loc_rdata = '0;
    endcase
  end

  pwm_guard_fault #(.N_FLT(N_FLT), .SYNC_STAGES(SYNC_STAGES)) u_fault (
    .clk(clk), .rst_n(rst_n), .flt_n(flt_n), .mask(mask_q), .clr(flt_clr),
    .flags(flags), .active(flt_act)
  );

  pwm_guard_osc #(.HALT_LIM(HALT_LIM), .SYNC_STAGES(SYNC_STAGES)) u_osc (
    .clk(clk), .ref_clk(ref_clk), .rst_n(rst_n), .clr_req(halt_clr),
    .halt_ref(halt_ref), .halt_seen(halt_seen), .starved(starved)
  );

  pwm_guard_adc u_adc (
    .clk(clk), .rst_n(rst_n), .en(trig_en_q), .match_a(match_a),
    .carrier_start(carrier_start), .adc_start(adc_start), .fire(adc_fire)
  );

  // the halt path is combinational from the reference domain on purpose
  assign trip   = (|flags) || halt_ref;
  assign pwm_oe = trip ? '0 : gen_oe;

endmodule

// File: rtl/pwm_guard_chk.sv
module pwm_guard_chk #(
  parameter int N_PHASE = 6,
  parameter int N_FLT   = 4,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               ref_clk,
  input logic               rst_n,
  input logic               cpu_wr,
  input logic               cpu_rd,
  input logic [ADDR_W-1:0]  cpu_addr,
  input logic [DATA_W-1:0]  cpu_rdata,
  input logic               gen_wr,
  input logic               gen_rd,
  input logic               lock_q,
  input logic               trig_en_q,
  input logic [N_FLT-1:0]   mask_q,
  input logic [N_FLT-1:0]   flags,
  input logic [N_FLT-1:0]   flt_act,
  input logic               halt_ref,
  input logic [N_PHASE-1:0] gen_oe,
  input logic [N_PHASE-1:0] pwm_oe,
  input logic               adc_start
);

  logic in_prot, in_buf;
  assign in_prot = !cpu_addr[ADDR_W-1] && !cpu_addr[ADDR_W-2];
  assign in_buf  = !cpu_addr[ADDR_W-1] &&  cpu_addr[ADDR_W-2];

  p_locked_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && lock_q && in_prot) |-> !gen_wr);

  p_locked_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && lock_q && in_prot) |-> (!gen_rd && cpu_rdata == '1));

  p_buffer_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && in_buf) |-> gen_wr);

  p_flag_trips_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags) |-> (pwm_oe == '0));

  p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags) & ~($past(flt_act) & $past(mask_q))) == '0));

  p_clear_inactive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flags & $past(flags) & $past(flt_act)) == '0));

  p_halt_trips_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    halt_ref |-> (pwm_oe == '0));

  p_adc_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  p_adc_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> $past(trig_en_q));

  p_oe_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0 && !halt_ref) |-> (pwm_oe == gen_oe));

endmodule

bind pwm_guard pwm_guard_chk #(
  .N_PHASE(N_PHASE), .N_FLT(N_FLT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .ref_clk(ref_clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata), .gen_wr(gen_wr), .gen_rd(gen_rd),
  .lock_q(lock_q), .trig_en_q(trig_en_q), .mask_q(mask_q), .flags(flags),
  .flt_act(flt_act), .halt_ref(halt_ref), .gen_oe(gen_oe), .pwm_oe(pwm_oe),
  .adc_start(adc_start)
);

// File: tb/pwm_guard_test.sv
`timescale 1ns/1ps
module pwm_guard_test;

  localparam logic [5:0] A_CTRL = 6'h20;
  localparam logic [5:0] A_MASK = 6'h21;
  localparam logic [5:0] A_STAT = 6'h22;
  localparam logic [5:0] OE_PAT = 6'b101101;

  logic        clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0, clk_run = 1'b1;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [5:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0, cpu_rdata;
  logic        gen_wr, gen_rd;
  logic [4:0]  gen_addr;
  logic [15:0] gen_wdata, gen_rdata;
  logic [3:0]  flt_n = 4'hF;
  logic [5:0]  gen_oe = OE_PAT, pwm_oe;
  logic        carrier_start = 1'b0, match_a = 1'b0, adc_start;

  int n_run = 0, n_fail = 0;

  always begin
    #10;
    if (clk_run) clk = ~clk;
  end
  always #85 ref_clk = ~ref_clk;

  // generator register model
  logic [15:0] gmem [32];
  initial for (int i = 0; i < 32; i++) gmem[i] = 16'h0;
  always @(posedge clk) if (gen_wr) gmem[gen_addr] <= gen_wdata;
  assign gen_rdata = gmem[gen_addr];

  pwm_guard uut (
    .clk(clk), .ref_clk(ref_clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .gen_wr(gen_wr), .gen_rd(gen_rd), .gen_addr(gen_addr), .gen_wdata(gen_wdata),
    .gen_rdata(gen_rdata), .flt_n(flt_n), .gen_oe(gen_oe), .pwm_oe(pwm_oe),
    .carrier_start(carrier_start), .match_a(match_a), .adc_start(adc_start)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d, output logic strobe);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #2;
    d = cpu_rdata; strobe = gen_rd;
    cpu_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] d; logic s;
    rd(A_CTRL, d, s); check("R1 ctrl", d, 0);
    rd(A_MASK, d, s); check("R1 mask", d, 16'h000F);
    rd(A_STAT, d, s); check("R1 stat", d, 0);
    check("R1/R11 oe", pwm_oe, OE_PAT);
  endtask

  task automatic t_lock;
    logic [15:0] d; logic s;
    wr(6'h03, 16'h1234);
    rd(6'h03, d, s); check("R4 unlocked rd", d, 16'h1234);
    check("R4 rd strobe", s, 1);
    wr(A_CTRL, 16'h0001);
    wr(6'h03, 16'hAAAA);
    rd(6'h03, d, s); check("R2 locked rd", d, 16'hFFFF);
    check("R2 no gen_rd", s, 0);
    wr(6'h12, 16'h5555);
    rd(6'h12, d, s); check("R3 buffer locked", d, 16'h5555);
    wr(A_CTRL, 16'h0000);
    rd(6'h03, d, s); check("R2 write discarded", d, 16'h1234);
  endtask

  task automatic t_pin;
    logic [15:0] d; logic s;
    @(negedge clk); flt_n[0] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); check("R5 oe tripped", pwm_oe, 0);
    rd(A_STAT, d, s); check("R5 flag", d, 16'h0001);
    wr(A_STAT, 16'h0001);
    rd(A_STAT, d, s); check("R7 clear while low", d, 16'h0001);
    @(negedge clk); flt_n[0] = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 still held", pwm_oe, 0);
    wr(A_STAT, 16'h0001);
    rd(A_STAT, d, s); check("R7 cleared", d, 0);
    check("R11 oe restored", pwm_oe, OE_PAT);
  endtask

  task automatic t_mask;
    logic [15:0] d; logic s;
    wr(A_MASK, 16'h000D);
    @(negedge clk); flt_n[1] = 1'b0;
    repeat (5) @(negedge clk);
    check("R6 oe kept", pwm_oe, OE_PAT);
    rd(A_STAT, d, s); check("R6 no flag", d, 0);
    flt_n[1] = 1'b1;
    repeat (3) @(negedge clk);
    wr(A_MASK, 16'h000F);
  endtask

  task automatic t_adc;
    wr(A_CTRL, 16'h0000);
    @(negedge clk); match_a = 1'b1;
    @(negedge clk); check("R10 disabled", adc_start, 0);
    match_a = 1'b0;
    wr(A_CTRL, 16'h0002);
    @(negedge clk); carrier_start = 1'b1;
    @(negedge clk); carrier_start = 1'b0; match_a = 1'b1;
    @(negedge clk); check("R10 pulse", adc_start, 1);
    @(negedge clk); check("R10 one cycle", adc_start, 0);
    match_a = 1'b0;
    @(negedge clk); match_a = 1'b1;
    @(negedge clk); check("R10 once per period", adc_start, 0);
    match_a = 1'b0; carrier_start = 1'b1;
    @(negedge clk); carrier_start = 1'b0; match_a = 1'b1;
    @(negedge clk); check("R10 next period", adc_start, 1);
    match_a = 1'b0;
    wr(A_CTRL, 16'h0000);
  endtask

  task automatic t_halt;
    logic [15:0] d; logic s;
    @(negedge clk); clk_run = 1'b0;
    #4000;
    check("R8 oe off without clk", pwm_oe, 0);
    clk_run = 1'b1;
    repeat (20) @(negedge clk);
    check("R9 held after restart", pwm_oe, 0);
    rd(A_STAT, d, s); check("R9 halt flag", d, 16'h0010);
    wr(A_STAT, 16'h0010);
    repeat (100) @(negedge clk);
    check("R9 released", pwm_oe, OE_PAT);
    rd(A_STAT, d, s); check("R9 flag cleared", d, 0);
  endtask

  initial begin
    #4_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_lock();
    t_pin();
    t_mask();
    t_adc();
    t_halt();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule